// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

A 32-bit processor core that completes one instruction per clock: the instruction is fetched, decoded, executed and retired between two rising edges. It covers a small load/store subset: word load, word store, five register-to-register operations (add, subtract, AND, OR, signed set-less-than) and branch-if-equal. The core has a program counter, a register file with two combinational read ports, an ALU, a sign extender, an adder used only for branch targets, a main control decoder and an ALU-operation decoder. Instruction and data storage are word arrays inside the block.

A test environment holds `rst` high and fills the instruction and data arrays through the preload ports. It then releases reset and lets the core run. It reads results through a registered register-file port and a registered data-array port. A branch back onto itself (`beq r0, r0, -1`) halts the program.

Instruction fields: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function code [5:0], 16-bit immediate [15:0].

Top module: `rsc_core`

## Requirements
- R1: While `rst` is high, `pc_q` is 0 and the core writes neither the register file nor the data array. Preload writes to both arrays are accepted in that time.
- R2: R-format (opcode 0x00) with function 0x20 (add), 0x22 (sub), 0x24 (and) or 0x25 (or) writes rs op rt, modulo 2^32, into rd.
- R3: When no taken branch executes, `pc_q` increases by 4 on each clock.
- R4: Function 0x2A (slt) writes 1 into rd if rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R5: Opcode 0x23 (lw) writes the data word at byte address rs + sign-extended immediate into rt. Negative offsets are included, and address bits [1:0] are ignored.
- R6: Opcode 0x2B (sw) stores rt at byte address rs + sign-extended immediate. No other instruction writes the data array.
- R7: Opcode 0x04 (beq) sets the next PC to PC + 4 + (sign-extended immediate << 2) when rs equals rt, and to PC + 4 otherwise. It writes no register.
- R8: Register 0 always reads 0, and writes addressed to it are dropped.
- R9: Any other opcode changes no register or data word, and the PC advances by 4.
- R10: An R-format word with any other function code writes no register.
- R11: `dbg_reg_data` and `dbg_mem_data` show the register and data word that were selected at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_imem_we | input | 1 | Preload write strobe for the instruction array |
| ld_imem_addr | input | clog2(IMEM_DEPTH) | Word index for instruction preload |
| ld_dmem_we | input | 1 | Preload write strobe for the data array (takes effect while rst is high) |
| ld_dmem_addr | input | clog2(DMEM_DEPTH) | Word index for data preload |
| ld_data | input | XLEN | Preload word |
| dbg_reg_sel | input | clog2(NREG) | Register to observe |
| dbg_reg_data | output | XLEN | Registered value of the selected register |
| dbg_mem_addr | input | clog2(DMEM_DEPTH) | Data word index to observe |
| dbg_mem_data | output | XLEN | Registered value of the selected data word |
| pc_q | output | XLEN | Program counter (byte address) |

## Verification
The bound checker checks several rules on every cycle: the fall-through and taken next-PC arithmetic, word alignment of the PC, that only stores write the data array, that only loads and R-format words write registers, and that unknown opcodes are silent. The ALU results, signed comparison at the sign boundary, negative load offsets, the drop of writes to register 0 and the suppression of unknown function codes can only be shown by the bench. It runs a program of operand pairs and special cases and compares the stored results with values it computes from the operands.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_class_e;

  typedef struct packed {
    logic       reg_dst;
    logic       alu_src;
    logic       mem_to_reg;
    logic       reg_write;
    logic       mem_read;
    logic       mem_write;
    logic       branch;
    alu_class_e alu_class;
  } ctrl_t;
endpackage

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alu_op_e    alu_op
);
  ctrl_t   base;
  logic    funct_ok;

  // main decoder
  always_comb begin
    base = '{reg_dst: 1'b0, alu_src: 1'b0, mem_to_reg: 1'b0, reg_write: 1'b0,
             mem_read: 1'b0, mem_write: 1'b0, branch: 1'b0, alu_class: AOP_ADD};
    unique case (opcode)
      OP_RTYPE: begin
        base.reg_dst   = 1'b1;
        base.reg_write = 1'b1;
        base.alu_class = AOP_FUNCT;
      end
      OP_LW: begin
        base.alu_src    = 1'b1;
        base.mem_to_reg = 1'b1;
        base.reg_write  = 1'b1;
        base.mem_read   = 1'b1;
      end
      OP_SW: begin
        base.alu_src   = 1'b1;
        base.mem_write = 1'b1;
      end
      OP_BEQ: begin
        base.branch    = 1'b1;
        base.alu_class = AOP_SUB;
      end
      default: ;
    endcase
  end

  // ALU operation decoder
  always_comb begin
    alu_op   = ALU_ADD;
    funct_ok = 1'b1;
    unique case (base.alu_class)
      AOP_ADD: alu_op = ALU_ADD;
      AOP_SUB: alu_op = ALU_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_ADD:  alu_op = ALU_ADD;
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: funct_ok = 1'b0;
        endcase
      end
      default: alu_op = ALU_ADD;
    endcase
  end

  always_comb begin
    ctrl           = base;
    ctrl.reg_write = base.reg_write & funct_ok;
  end
endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
  import rsc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_op_e      op,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2,
  input  logic [AW-1:0] dbg_sel,
  output logic [W-1:0]  dbg_data
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  always_ff @(posedge clk) begin
    dbg_data <= (dbg_sel == '0) ? '0 : regs[dbg_sel];
  end
endmodule

// File: rtl/rsc_dmem.sv
module rsc_dmem #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [W-1:0]  dbg_data
);
  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];

  always_ff @(posedge clk) begin
    dbg_data <= words[dbg_addr];
  end
endmodule

// File: rtl/rsc_core.sv
module rsc_core
  import rsc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 32,
  parameter int IMEM_DEPTH = 128,
  parameter int DMEM_DEPTH = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ld_imem_we,
  input  logic [$clog2(IMEM_DEPTH)-1:0] ld_imem_addr,
  input  logic                          ld_dmem_we,
  input  logic [$clog2(DMEM_DEPTH)-1:0] ld_dmem_addr,
  input  logic [XLEN-1:0]               ld_data,
  input  logic [$clog2(NREG)-1:0]       dbg_reg_sel,
  output logic [XLEN-1:0]               dbg_reg_data,
  input  logic [$clog2(DMEM_DEPTH)-1:0] dbg_mem_addr,
  output logic [XLEN-1:0]               dbg_mem_data,
  output logic [XLEN-1:0]               pc_q
);
  localparam int IAW = $clog2(IMEM_DEPTH);
  localparam int DAW = $clog2(DMEM_DEPTH);
  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] imem [IMEM_DEPTH];
  logic [XLEN-1:0] instr;
  logic [XLEN-1:0] pc_plus4, br_target, pc_next, imm_ext;
  logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, mem_rdata, wb_data;
  logic [RAW-1:0]  rf_waddr;
  logic            rf_we, dm_we, alu_zero, br_taken;
  logic [DAW-1:0]  dm_waddr;
  logic [XLEN-1:0] dm_wdata;
  ctrl_t           ctrl;
  alu_op_e         alu_op;

  // instruction array: preload write, combinational fetch
  always_ff @(posedge clk) begin
    if (ld_imem_we) imem[ld_imem_addr] <= ld_data;
  end
  assign instr = imem[pc_q[IAW+1:2]];

  rsc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .alu_op (alu_op)
  );

  assign imm_ext  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign rf_waddr = ctrl.reg_dst ? instr[11+RAW-1:11] : instr[16+RAW-1:16];
  assign rf_we    = ctrl.reg_write & ~rst;

  rsc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .we       (rf_we),
    .waddr    (rf_waddr),
    .wdata    (wb_data),
    .ra1      (instr[21+RAW-1:21]),
    .ra2      (instr[16+RAW-1:16]),
    .rd1      (rd1),
    .rd2      (rd2),
    .dbg_sel  (dbg_reg_sel),
    .dbg_data (dbg_reg_data)
  );

  assign alu_b = ctrl.alu_src ? imm_ext : rd2;

  rsc_alu #(.W(XLEN)) u_alu (
    .a    (rd1),
    .b    (alu_b),
    .op   (alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data array: preload owns the write port during reset
  assign dm_we    = rst ? ld_dmem_we   : ctrl.mem_write;
  assign dm_waddr = rst ? ld_dmem_addr : alu_y[DAW+1:2];
  assign dm_wdata = rst ? ld_data      : rd2;

  rsc_dmem #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dm (
    .clk      (clk),
    .we       (dm_we),
    .waddr    (dm_waddr),
    .wdata    (dm_wdata),
    .raddr    (alu_y[DAW+1:2]),
    .rdata    (mem_rdata),
    .dbg_addr (dbg_mem_addr),
    .dbg_data (dbg_mem_data)
  );

  assign wb_data = ctrl.mem_to_reg ? mem_rdata : alu_y;

  // next PC: dedicated branch-target adder
  assign pc_plus4  = pc_q + XLEN'(4);
  assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign br_taken  = ctrl.branch & alu_zero;
  assign pc_next   = br_taken ? br_target : pc_plus4;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  logic unused_bits;
  assign unused_bits = ^{pc_q[XLEN-1:IAW+2], pc_q[1:0], instr[10:6], ctrl.mem_read,
                         alu_y[XLEN-1:DAW+2], alu_y[1:0]};
endmodule

// File: rtl/rsc_core_chk.sv
module rsc_core_chk
  import rsc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] instr,
  input logic            rf_we,
  input logic            dm_we,
  input logic            alu_zero
);
  logic [5:0] op;
  logic       known_op;
  assign op       = instr[31:26];
  assign known_op = (op == OP_RTYPE) || (op == OP_LW) || (op == OP_SW) || (op == OP_BEQ);

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(op == OP_BEQ && alu_zero) |=> pc_q == $past(pc_q) + XLEN'(4));

  // R7
  pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BEQ && alu_zero) |=> pc_q == $past(pc_q) + XLEN'(4)
      + {{(XLEN-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00});

  // R3
  pc_align_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  // R6
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    dm_we |-> op == OP_SW);

  // R9
  unknown_silent_chk: assert property (@(posedge clk) disable iff (rst)
    !known_op |-> (!rf_we && !dm_we));

  // R7
  reg_writer_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (op == OP_RTYPE || op == OP_LW));
endmodule

bind rsc_core rsc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc_q     (pc_q),
  .instr    (instr),
  .rf_we    (rf_we),
  .dm_we    (dm_we),
  .alu_zero (alu_zero)
);

// File: tb/rsc_core_bench.sv
module rsc_core_bench;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int IMEM_DEPTH = 128;
  localparam int DMEM_DEPTH = 64;
  localparam int NPAIR = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_imem_we = 1'b0;
  logic [6:0] ld_imem_addr = '0;
  logic ld_dmem_we = 1'b0;
  logic [5:0] ld_dmem_addr = '0;
  logic [31:0] ld_data = '0;
  logic [4:0] dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data;
  logic [5:0] dbg_mem_addr = '0;
  logic [31:0] dbg_mem_data;
  logic [31:0] pc_q;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rsc_core #(.XLEN(XLEN), .NREG(NREG), .IMEM_DEPTH(IMEM_DEPTH), .DMEM_DEPTH(DMEM_DEPTH))
  u_rsc_core (
    .clk(clk), .rst(rst),
    .ld_imem_we(ld_imem_we), .ld_imem_addr(ld_imem_addr),
    .ld_dmem_we(ld_dmem_we), .ld_dmem_addr(ld_dmem_addr), .ld_data(ld_data),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
    .pc_q(pc_q)
  );

  logic [31:0] prog [IMEM_DEPTH];
  logic [31:0] dat  [DMEM_DEPTH];
  logic [31:0] opa  [NPAIR];
  logic [31:0] opb  [NPAIR];

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic read_reg(int sel, output logic [31:0] v);
    @(negedge clk) dbg_reg_sel = 5'(sel);
    @(posedge clk);
    @(negedge clk) v = dbg_reg_data;
  endtask

  task automatic read_mem(int adr, output logic [31:0] v);
    @(negedge clk) dbg_mem_addr = 6'(adr);
    @(posedge clk);
    @(negedge clk) v = dbg_mem_data;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp [5];
    opa[0] = 32'd5;          opb[0] = 32'd3;
    opa[1] = 32'd3;          opb[1] = 32'd5;
    opa[2] = 32'hFFFF_FFFF;  opb[2] = 32'd1;
    opa[3] = 32'h8000_0000;  opb[3] = 32'd1;
    opa[4] = 32'd7;          opb[4] = 32'd7;
    opa[5] = 32'h7FFF_FFFF;  opb[5] = 32'hFFFF_FFFF;
    opa[6] = 32'hF0F0_F0F0;  opb[6] = 32'h0FF0_0FF0;
    opa[7] = 32'd0;          opb[7] = 32'd0;

    for (int i = 0; i < DMEM_DEPTH; i++) dat[i] = '0;
    for (int i = 0; i < NPAIR; i++) begin
      dat[2*i] = opa[i];
      dat[2*i+1] = opb[i];
    end
    dat[56] = 32'h0000_1234;
    dat[57] = 32'd240;
    dat[58] = 32'h0000_BEEF;
    dat[59] = 32'h0000_CAFE;
    dat[60] = 32'h0000_5555;

    for (int i = 0; i < IMEM_DEPTH; i++) prog[i] = '0;
    for (int i = 0; i < NPAIR; i++) begin
      prog[12*i+0]  = enc_i(6'h23, 0, 1, 16'(8*i));
      prog[12*i+1]  = enc_i(6'h23, 0, 2, 16'(8*i+4));
      prog[12*i+2]  = enc_r(1, 2, 3, 6'h20);
      prog[12*i+3]  = enc_r(1, 2, 4, 6'h22);
      prog[12*i+4]  = enc_r(1, 2, 5, 6'h24);
      prog[12*i+5]  = enc_r(1, 2, 6, 6'h25);
      prog[12*i+6]  = enc_r(1, 2, 7, 6'h2A);
      for (int k = 0; k < 5; k++)
        prog[12*i+7+k] = enc_i(6'h2B, 0, 3+k, 16'((16+5*i+k)*4));
    end
    prog[96]  = enc_i(6'h23, 0, 8, 16'd224);
    prog[97]  = enc_i(6'h08, 0, 8, 16'd5);
    prog[98]  = enc_r(1, 2, 8, 6'h21);
    prog[99]  = enc_r(8, 8, 0, 6'h20);
    prog[100] = enc_i(6'h23, 0, 12, 16'd228);
    prog[101] = enc_i(6'h23, 12, 11, 16'hFFFC);
    prog[102] = enc_i(6'h23, 0, 9, 16'd228);
    prog[103] = enc_i(6'h23, 0, 10, 16'd228);
    prog[104] = enc_i(6'h04, 8, 8, 16'd1);
    prog[105] = enc_i(6'h23, 0, 9, 16'd232);
    prog[106] = enc_i(6'h04, 8, 12, 16'd1);
    prog[107] = enc_i(6'h23, 0, 10, 16'd232);
    prog[108] = enc_i(6'h2B, 0, 0, 16'd240);
    prog[109] = enc_i(6'h04, 0, 0, 16'hFFFF);

    for (int i = 0; i < IMEM_DEPTH; i++) begin
      @(negedge clk);
      ld_imem_we = 1'b1; ld_imem_addr = 7'(i); ld_data = prog[i];
    end
    for (int i = 0; i < DMEM_DEPTH; i++) begin
      @(negedge clk);
      ld_imem_we = 1'b0;
      ld_dmem_we = 1'b1; ld_dmem_addr = 6'(i); ld_data = dat[i];
    end
    @(negedge clk);
    ld_dmem_we = 1'b0;
    check("R1 pc in reset", pc_q, 32'd0);

    rst = 1'b0;
    repeat (300) @(posedge clk);

    for (int i = 0; i < NPAIR; i++) begin
      exp[0] = opa[i] + opb[i];
      exp[1] = opa[i] - opb[i];
      exp[2] = opa[i] & opb[i];
      exp[3] = opa[i] | opb[i];
      exp[4] = ($signed(opa[i]) < $signed(opb[i])) ? 32'd1 : 32'd0;
      for (int k = 0; k < 5; k++) begin
        read_mem(16 + 5*i + k, v);
        check(k == 4 ? "R4 slt signed" : "R2 R-format op", v, exp[k]);
      end
    end

    read_reg(8, v);  check("R9 R10 r8 untouched by unknown op/funct", v, 32'h0000_1234);
    read_reg(0, v);  check("R8 r0 reads zero", v, 32'd0);
    read_mem(60, v); check("R8 R6 sw of r0 stores zero", v, 32'd0);
    read_reg(12, v); check("R11 registered debug read", v, 32'd240);
    read_reg(11, v); check("R5 lw negative offset", v, 32'h0000_CAFE);
    read_reg(9, v);  check("R7 taken beq skips", v, 32'd240);
    read_reg(10, v); check("R7 untaken beq falls through", v, 32'h0000_BEEF);
    read_mem(0, v);  check("R6 unstored word kept", v, opa[0]);
    read_mem(59, v); check("R6 unstored word kept", v, 32'h0000_CAFE);
    check("R3 halted pc", pc_q, 32'd436);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule